// File: doc/BRIEF.md
# NAND Flash Read Command Sequencer

This block runs an 8-bit asynchronous NAND flash bus on behalf of a simple request port. One request picks one of four operations: device reset, identification read, full page read, or spare-area read. The block issues the command-latch and address-latch write cycles, produces the write and read strobes, holds chip enable for the whole operation, and waits for the device. Bytes read from the array or the ID come out as a stream with a one-cycle valid strobe.

The requester supplies a linear byte offset. The sequencer splits it into two column cycles and either two or three page cycles, depending on device size. A spare-area request sets a flag in the second column cycle so that the column points past the data area. After a reset the ready/busy pin is not used. The block reads the status register until its ready bit is set. After an identification read, a flag reports whether the manufacturer and device bytes are on the accepted list.

Top module: `nand_rd_seq`

## Requirements
- R1: Operation codes on `reqOp` are 0 = reset, 1 = identify, 2 = page read, 3 = spare read. A request is taken when `reqValid` is high while `reqReady` is high. `reqReady` is low from acceptance until after `done`, and a `reqValid` seen while it is low has no effect on the bus.
- R2: Every write cycle has CLE or ALE (never both) high, with the byte driven (`nandIoOe` high), for exactly LATCH_CYC cycles before `nandWeN` falls and LATCH_CYC cycles after it rises. `nandWeN` stays low for exactly WE_LOW_CYC cycles.
- R3: Each read strobe holds `nandReN` low for RE_LOW_CYC cycles. Consecutive strobes within one burst are separated by exactly RE_HIGH_CYC high cycles. The input byte is sampled at the end of the low phase, and `dataValid` pulses for one cycle per emitted byte.
- R4: A page read writes command 0x00, then column byte offset[7:0], then column byte {5'b0, offset[10:8]}, then page bytes offset[18:11] and offset[26:19]. A third page byte offset[34:27] follows only when CHIP_MIB > 128. The last write is command 0x30.
- R5: After the 0x30 command, no read strobe is issued until BUSY_DLY cycles have passed and `nandRb` is high.
- R6: A page read streams PAGE_BYTES + SPARE_BYTES (2112) bytes in device order.
- R7: A spare read uses the same sequence as R4, except that bit 3 of the second column byte is set. It streams SPARE_BYTES (64) bytes.
- R8: A reset writes command 0xFF, then command 0x70. It then issues status reads until a status byte has bit 6 set. Status bytes are not put on the data stream.
- R9: An identify operation writes command 0x90, then one address byte 0x00, then reads two bytes (manufacturer, device), and both appear on the data stream. `idMatch` is set after the second byte when the pair is 0x2C with 0xA1, 0xBA or 0xBC, or 0xEC with 0xA1. It holds until the next identify.
- R10: `nandCeN` is low from the first command cycle to the last read. It is high for at least one cycle before the single-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 2 | Operation code |
| reqOffset | input | ADDR_W | Linear byte offset (column and page) |
| reqReady | output | 1 | Idle, able to take a request |
| done | output | 1 | One-cycle end-of-operation pulse |
| dataValid | output | 1 | Read byte strobe |
| dataByte | output | 8 | Read byte |
| idMatch | output | 1 | Last identify matched the accepted list |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandIoOut | output | 8 | Byte driven onto the bus |
| nandIoOe | output | 1 | Bus output enable |
| nandIoIn | input | 8 | Byte from the bus |
| nandRb | input | 1 | Ready (high) / busy (low) |

## Verification
The hardest case to reach from the ports is the status poll after a reset. It only repeats if the device keeps returning status with bit 6 clear. The bench's device model therefore answers a set number of polls as busy before it reports ready, and then checks how many status reads were made. The second hard case is a request arriving mid-operation. The bench pulses `reqValid` in the middle of a 2112-byte page stream. Any extra bus cycle it caused would break the ordered write and data scoreboards.

// File: rtl/nandseq_pkg.sv
`timescale 1ns/1ps
package nandseq_pkg;

  typedef enum logic [1:0] {
    OP_RESET  = 2'd0,
    OP_READID = 2'd1,
    OP_PAGE   = 2'd2,
    OP_SPARE  = 2'd3
  } opE;

  typedef enum logic [2:0] {
    SK_CMD, SK_ADDR, SK_WAIT, SK_READ, SK_POLL, SK_END
  } stepKindE;

  typedef struct packed {
    stepKindE   kind;
    logic [7:0] value;
  } stepT;

  typedef enum logic [1:0] {
    RK_DATA, RK_ID, RK_STATUS
  } rdKindE;

  // control -> datapath strobes
  typedef struct packed {
    logic       ceOn;
    logic       wrGo;
    logic       wrCle;
    logic [7:0] wrByte;
    logic       rdGo;
    rdKindE     rdKind;
  } strobeT;

  localparam logic [7:0] CMD_ARRAY   = 8'h00;
  localparam logic [7:0] CMD_CONFIRM = 8'h30;
  localparam logic [7:0] CMD_RESET   = 8'hFF;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam int         READY_BIT   = 6;

  function automatic logic idAccepted(logic [7:0] mfr, logic [7:0] dev);
    logic ok;
    ok = 1'b0;
    if (mfr == 8'h2C && (dev == 8'hA1 || dev == 8'hBA || dev == 8'hBC)) ok = 1'b1;
    if (mfr == 8'hEC && dev == 8'hA1) ok = 1'b1;
    return ok;
  endfunction

endpackage

// File: rtl/nandseq_ctrl.sv
`timescale 1ns/1ps
module nandseq_ctrl
  import nandseq_pkg::*;
#(
  parameter int PAGE_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int CHIP_MIB    = 256,
  parameter int ADDR_W      = 35,
  parameter int BUSY_DLY    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic              nandRb,
  input  logic              cycDone,
  input  logic              statusReady,
  output logic              reqReady,
  output logic              done,
  output strobeT            strb
);

  localparam int  COL_BITS = $clog2(PAGE_BYTES);
  localparam int  HI_W     = COL_BITS - 8;
  localparam bit  BIG      = (CHIP_MIB > 128);
  localparam int  RCNT_W   = $clog2(PAGE_BYTES + SPARE_BYTES + 1);
  localparam int  WAIT_W   = $clog2(BUSY_DLY + 1);

  typedef enum logic [3:0] {
    C_IDLE, C_ISSUE, C_WR, C_WAITDLY, C_WAITRB, C_RD, C_POLL, C_FIN, C_DONE
  } ctrlStateE;

  ctrlStateE         state;
  opE                opReg;
  logic [ADDR_W-1:0] offReg;
  logic [3:0]        stepIdx;
  logic [RCNT_W-1:0] rdLeft;
  logic [WAIT_W-1:0] waitCnt;
  stepT              curStep;
  logic [RCNT_W-1:0] firstLeft;
  rdKindE            burstKind;

  function automatic stepT stepOf(opE op, logic [3:0] idx, logic [ADDR_W-1:0] off);
    stepT       s;
    logic [3:0] j;
    logic [7:0] colHi;
    s.kind  = SK_END;
    s.value = 8'h00;
    colHi   = 8'h00;
    colHi[HI_W-1:0] = off[COL_BITS-1:8];
    colHi[HI_W]     = (op == OP_SPARE);
    unique case (op)
      OP_RESET: begin
        case (idx)
          4'd0: begin s.kind = SK_CMD; s.value = CMD_RESET;  end
          4'd1: begin s.kind = SK_CMD; s.value = CMD_STATUS; end
          4'd2: s.kind = SK_POLL;
          default: s.kind = SK_END;
        endcase
      end
      OP_READID: begin
        case (idx)
          4'd0: begin s.kind = SK_CMD;  s.value = CMD_IDENT; end
          4'd1: begin s.kind = SK_ADDR; s.value = 8'h00;     end
          4'd2: s.kind = SK_READ;
          default: s.kind = SK_END;
        endcase
      end
      default: begin
        // skip the third page cycle on small devices
        j = (!BIG && idx >= 4'd5) ? idx + 4'd1 : idx;
        case (j)
          4'd0: begin s.kind = SK_CMD;  s.value = CMD_ARRAY;                  end
          4'd1: begin s.kind = SK_ADDR; s.value = off[7:0];                   end
          4'd2: begin s.kind = SK_ADDR; s.value = colHi;                      end
          4'd3: begin s.kind = SK_ADDR; s.value = off[COL_BITS +: 8];         end
          4'd4: begin s.kind = SK_ADDR; s.value = off[COL_BITS + 8 +: 8];     end
          4'd5: begin s.kind = SK_ADDR; s.value = off[COL_BITS + 16 +: 8];    end
          4'd6: begin s.kind = SK_CMD;  s.value = CMD_CONFIRM;                end
          4'd7: s.kind = SK_WAIT;
          4'd8: s.kind = SK_READ;
          default: s.kind = SK_END;
        endcase
      end
    endcase
    return s;
  endfunction

  assign curStep   = stepOf(opReg, stepIdx, offReg);
  assign firstLeft = (opReg == OP_PAGE)  ? RCNT_W'(PAGE_BYTES + SPARE_BYTES - 1) :
                     (opReg == OP_SPARE) ? RCNT_W'(SPARE_BYTES - 1) : RCNT_W'(1);
  assign burstKind = (opReg == OP_READID) ? RK_ID : RK_DATA;

  always_comb begin
    strb        = '0;
    strb.rdKind = RK_DATA;
    strb.ceOn   = !(state == C_IDLE || state == C_FIN || state == C_DONE);
    unique case (state)
      C_ISSUE: begin
        case (curStep.kind)
          SK_CMD:  begin strb.wrGo = 1'b1; strb.wrCle = 1'b1; strb.wrByte = curStep.value; end
          SK_ADDR: begin strb.wrGo = 1'b1; strb.wrByte = curStep.value; end
          SK_READ: begin strb.rdGo = 1'b1; strb.rdKind = burstKind; end
          SK_POLL: begin strb.rdGo = 1'b1; strb.rdKind = RK_STATUS; end
          default: ;
        endcase
      end
      C_RD: begin
        if (cycDone && rdLeft != '0) begin strb.rdGo = 1'b1; strb.rdKind = burstKind; end
      end
      C_POLL: begin
        if (cycDone && !statusReady) begin strb.rdGo = 1'b1; strb.rdKind = RK_STATUS; end
      end
      default: ;
    endcase
  end

  assign reqReady = (state == C_IDLE);
  assign done     = (state == C_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= C_IDLE;
      opReg   <= OP_RESET;
      offReg  <= '0;
      stepIdx <= '0;
      rdLeft  <= '0;
      waitCnt <= '0;
    end else begin
      unique case (state)
        C_IDLE: begin
          if (reqValid) begin
            opReg   <= opE'(reqOp);
            offReg  <= reqOffset;
            stepIdx <= '0;
            state   <= C_ISSUE;
          end
        end
        C_ISSUE: begin
          case (curStep.kind)
            SK_CMD, SK_ADDR: state <= C_WR;
            SK_WAIT: begin waitCnt <= WAIT_W'(BUSY_DLY - 1); state <= C_WAITDLY; end
            SK_READ: begin rdLeft <= firstLeft; state <= C_RD; end
            SK_POLL: state <= C_POLL;
            default: state <= C_FIN;
          endcase
        end
        C_WR: begin
          if (cycDone) begin stepIdx <= stepIdx + 4'd1; state <= C_ISSUE; end
        end
        C_WAITDLY: begin
          if (waitCnt == '0) state <= C_WAITRB;
          else waitCnt <= waitCnt - WAIT_W'(1);
        end
        C_WAITRB: begin
          if (nandRb) begin stepIdx <= stepIdx + 4'd1; state <= C_ISSUE; end
        end
        C_RD: begin
          if (cycDone) begin
            if (rdLeft == '0) begin stepIdx <= stepIdx + 4'd1; state <= C_ISSUE; end
            else rdLeft <= rdLeft - RCNT_W'(1);
          end
        end
        C_POLL: begin
          if (cycDone && statusReady) begin stepIdx <= stepIdx + 4'd1; state <= C_ISSUE; end
        end
        C_FIN:  state <= C_DONE;
        default: state <= C_IDLE;
      endcase
    end
  end

  // R10: chip enable released the cycle before done
  assert_ce_off_before_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!strb.ceOn && $past(!strb.ceOn)));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: no read strobe while the device reports busy
  assert_no_read_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == C_WAITRB && !nandRb) |-> !strb.rdGo);

endmodule

// File: rtl/nandseq_dp.sv
`timescale 1ns/1ps
module nandseq_dp
  import nandseq_pkg::*;
#(
  parameter int LATCH_CYC   = 2,
  parameter int WE_LOW_CYC  = 2,
  parameter int RE_LOW_CYC  = 2,
  parameter int RE_HIGH_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     strb,
  input  logic [7:0] nandIoIn,
  output logic       cycDone,
  output logic       statusReady,
  output logic       dataValid,
  output logic [7:0] dataByte,
  output logic       idMatch,
  output logic       nandCeN,
  output logic       nandCle,
  output logic       nandAle,
  output logic       nandWeN,
  output logic       nandReN,
  output logic [7:0] nandIoOut,
  output logic       nandIoOe
);

  localparam int CNT_W = $clog2(LATCH_CYC + WE_LOW_CYC + RE_LOW_CYC + RE_HIGH_CYC + 1);

  typedef enum logic [2:0] {
    P_IDLE, P_SETUP, P_WLOW, P_HOLD, P_RLOW, P_RHIGH
  } phaseE;

  phaseE            phase;
  logic [CNT_W-1:0] phCnt;
  logic             latchCle;
  logic [7:0]       wrByte;
  rdKindE           rdKind;
  logic [7:0]       mfrReg;
  logic             idSecond;
  logic             inWrite;
  logic             sampleNow;

  assign inWrite   = (phase == P_SETUP || phase == P_WLOW || phase == P_HOLD);
  assign cycDone   = (phase == P_HOLD || phase == P_RHIGH) && (phCnt == '0);
  assign sampleNow = (phase == P_RLOW) && (phCnt == '0);

  assign nandCeN   = !strb.ceOn;
  assign nandCle   = inWrite && latchCle;
  assign nandAle   = inWrite && !latchCle;
  assign nandWeN   = (phase != P_WLOW);
  assign nandReN   = (phase != P_RLOW);
  assign nandIoOe  = inWrite;
  assign nandIoOut = wrByte;

  // strobe timing engine
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= P_IDLE;
      phCnt    <= '0;
      latchCle <= 1'b0;
      wrByte   <= '0;
      rdKind   <= RK_DATA;
    end else if (strb.wrGo) begin
      phase    <= P_SETUP;
      phCnt    <= CNT_W'(LATCH_CYC - 1);
      latchCle <= strb.wrCle;
      wrByte   <= strb.wrByte;
    end else if (strb.rdGo) begin
      phase  <= P_RLOW;
      phCnt  <= CNT_W'(RE_LOW_CYC - 1);
      rdKind <= strb.rdKind;
    end else if (phCnt != '0) begin
      phCnt <= phCnt - CNT_W'(1);
    end else begin
      unique case (phase)
        P_SETUP: begin phase <= P_WLOW; phCnt <= CNT_W'(WE_LOW_CYC - 1); end
        P_WLOW:  begin phase <= P_HOLD; phCnt <= CNT_W'(LATCH_CYC - 1);  end
        P_RLOW:  begin phase <= P_RHIGH; phCnt <= CNT_W'(RE_HIGH_CYC - 1); end
        default: phase <= P_IDLE;
      endcase
    end
  end

  // read capture, data stream and ID compare
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataValid   <= 1'b0;
      dataByte    <= '0;
      statusReady <= 1'b0;
      mfrReg      <= '0;
      idSecond    <= 1'b0;
      idMatch     <= 1'b0;
    end else begin
      dataValid <= 1'b0;
      if (sampleNow) begin
        if (rdKind == RK_STATUS) begin
          statusReady <= nandIoIn[READY_BIT];
        end else begin
          dataValid <= 1'b1;
          dataByte  <= nandIoIn;
          if (rdKind == RK_ID) begin
            if (!idSecond) begin
              mfrReg   <= nandIoIn;
              idSecond <= 1'b1;
            end else begin
              idMatch  <= idAccepted(mfrReg, nandIoIn);
              idSecond <= 1'b0;
            end
          end
        end
      end
    end
  end

  assert_latch_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  assert_we_framed_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nandWeN) |-> (nandIoOe && (nandCle || nandAle)));

  assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  assert_go_when_free_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrGo || strb.rdGo) |-> (phase == P_IDLE || cycDone));

  assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  assert_ce_covers_strobes_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN || !nandReN) |-> !nandCeN);

endmodule

// File: rtl/nand_rd_seq.sv
`timescale 1ns/1ps
module nand_rd_seq
  import nandseq_pkg::*;
#(
  parameter int PAGE_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int CHIP_MIB    = 256,
  parameter int ADDR_W      = $clog2(PAGE_BYTES) + 24,
  parameter int LATCH_CYC   = 2,
  parameter int WE_LOW_CYC  = 2,
  parameter int RE_LOW_CYC  = 2,
  parameter int RE_HIGH_CYC = 2,
  parameter int BUSY_DLY    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqOffset,
  output logic              reqReady,
  output logic              done,
  output logic              dataValid,
  output logic [7:0]        dataByte,
  output logic              idMatch,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [7:0]        nandIoOut,
  output logic              nandIoOe,
  input  logic [7:0]        nandIoIn,
  input  logic              nandRb
);

  strobeT strb;
  logic   cycDone;
  logic   statusReady;

  nandseq_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .SPARE_BYTES(SPARE_BYTES), .CHIP_MIB(CHIP_MIB),
    .ADDR_W(ADDR_W), .BUSY_DLY(BUSY_DLY)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqOffset(reqOffset),
    .nandRb(nandRb), .cycDone(cycDone), .statusReady(statusReady),
    .reqReady(reqReady), .done(done), .strb(strb)
  );

  nandseq_dp #(
    .LATCH_CYC(LATCH_CYC), .WE_LOW_CYC(WE_LOW_CYC),
    .RE_LOW_CYC(RE_LOW_CYC), .RE_HIGH_CYC(RE_HIGH_CYC)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .nandIoIn(nandIoIn),
    .cycDone(cycDone), .statusReady(statusReady),
    .dataValid(dataValid), .dataByte(dataByte), .idMatch(idMatch),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandIoOut(nandIoOut), .nandIoOe(nandIoOe)
  );

endmodule

// File: tb/sim_nand_rd_seq.sv
`timescale 1ns/1ps
module sim_nand_rd_seq;

  localparam int LAT = 2, WEL = 2, REL = 2, REH = 2, BDLY = 4;
  localparam int PG = 2048, SP = 64, AW = 35;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = 2'd0;
  logic [AW-1:0] reqOffset = '0;
  logic          reqReady, done, dataValid, idMatch;
  logic [7:0]    dataByte, nandIoOut, nandIoIn;
  logic          nandCeN, nandCle, nandAle, nandWeN, nandReN, nandIoOe;
  logic          nandRb;

  nand_rd_seq #(
    .PAGE_BYTES(PG), .SPARE_BYTES(SP), .CHIP_MIB(256), .ADDR_W(AW),
    .LATCH_CYC(LAT), .WE_LOW_CYC(WEL), .RE_LOW_CYC(REL), .RE_HIGH_CYC(REH), .BUSY_DLY(BDLY)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqOffset(reqOffset),
    .reqReady(reqReady), .done(done), .dataValid(dataValid), .dataByte(dataByte),
    .idMatch(idMatch), .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandIoOut(nandIoOut), .nandIoOe(nandIoOe),
    .nandIoIn(nandIoIn), .nandRb(nandRb)
  );

  int total = 0;
  int bad   = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard queues
  logic [9:0] expWr[$];
  string      expWrTag[$];
  logic [7:0] expData[$];
  string      expDataTag[$];

  task automatic expectWr(bit cle, bit ale, logic [7:0] b, string tag);
    expWr.push_back({cle, ale, b});
    expWrTag.push_back(tag);
  endtask

  task automatic expectData(logic [7:0] b, string tag);
    expData.push_back(b);
    expDataTag.push_back(tag);
  endtask

  function automatic logic [7:0] pageByte(int k);
    return 8'(k) ^ 8'((k >> 8) * 8'h35) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] spareByte(int k);
    return 8'hC3 ^ 8'(k * 3);
  endfunction

  // device model state
  typedef enum int {MD_NONE, MD_STAT, MD_ID, MD_PAGE} modeE;
  modeE       mode;
  int         ptr, pollCnt, busyCnt, addrIdx;
  bit         spareSel, rbReg;
  int         pollTarget = 0;
  logic [7:0] idMfr = 8'h00, idDev = 8'h00;

  // pin monitors
  bit prevWe, prevRe, prevLatch, prevCeN, weSeen, reStream;
  int setupCnt, holdCnt, weLow, reLow, reHigh;

  assign nandRb   = rbReg;
  assign nandIoIn = (mode == MD_STAT) ? ((pollCnt >= pollTarget) ? 8'hE0 : 8'hA0) :
                    (mode == MD_ID)   ? ((ptr == 0) ? idMfr : idDev) :
                    (mode == MD_PAGE) ? (spareSel ? spareByte(ptr) : pageByte(ptr)) : 8'h00;

  always @(negedge clk) begin
    if (!rstN) begin
      mode = MD_NONE; ptr = 0; pollCnt = 0; busyCnt = 0; addrIdx = 0;
      spareSel = 0; rbReg = 1;
      prevWe = 1; prevRe = 1; prevLatch = 0; prevCeN = 1; weSeen = 0; reStream = 0;
      setupCnt = 0; holdCnt = 0; weLow = 0; reLow = 0; reHigh = 0;
    end else begin
      bit latchOn;
      latchOn = nandCle || nandAle;
      if (busyCnt > 0) begin
        busyCnt--;
        if (busyCnt == 0) rbReg = 1;
      end
      // write strobe edges
      if (prevWe && !nandWeN) begin
        check(setupCnt == LAT && nandIoOe, "R2", "latch setup cycles", setupCnt, LAT);
        weSeen = 1; weLow = 0;
      end
      if (!prevWe && nandWeN) begin
        logic [9:0] obs;
        check(weLow == WEL, "R2", "write strobe low cycles", weLow, WEL);
        obs = {nandCle, nandAle, nandIoOut};
        if (expWr.size() == 0) check(0, "R1", "unexpected bus write", obs, 0);
        else begin
          logic [9:0] e;
          string t;
          e = expWr.pop_front(); t = expWrTag.pop_front();
          check(obs == e, t, "bus write", obs, e);
        end
        if (nandCle) begin
          case (nandIoOut)
            8'hFF: begin mode = MD_NONE; pollCnt = 0; end
            8'h70: begin mode = MD_STAT; pollCnt = 0; end
            8'h90: begin mode = MD_ID; ptr = 0; end
            8'h00: begin mode = MD_PAGE; addrIdx = 0; ptr = 0; end
            8'h30: begin rbReg = 0; busyCnt = 12; ptr = 0; end
            default: ;
          endcase
        end else begin
          if (addrIdx == 1) spareSel = nandIoOut[3];
          addrIdx++;
        end
      end
      if (prevLatch && !latchOn) begin
        check(holdCnt == LAT, "R2", "latch hold cycles", holdCnt, LAT);
        setupCnt = 0; holdCnt = 0; weSeen = 0;
      end
      // read strobe edges
      if (prevRe && !nandReN) begin
        check(rbReg == 1, "R5", "read strobe while busy", 0, 1);
        if (reStream) check(reHigh == REH, "R3", "read strobe high cycles", reHigh, REH);
        reLow = 0;
      end
      if (!prevRe && nandReN) begin
        check(reLow == REL, "R3", "read strobe low cycles", reLow, REL);
        if (mode == MD_STAT) pollCnt++; else ptr++;
        reHigh = 0; reStream = 1;
      end
      // counters for this sample
      if (latchOn && nandWeN) begin
        if (weSeen) holdCnt++; else setupCnt++;
      end
      if (!nandWeN) weLow++;
      if (!nandReN) reLow++; else reHigh++;
      if (nandCeN) reStream = 0;
      if ((!nandWeN || !nandReN) && nandCeN)
        check(0, "R10", "strobe with chip disabled", 1, 0);
      // data stream scoreboard
      if (dataValid) begin
        if (expData.size() == 0) check(0, "R8", "unexpected data byte", dataByte, 0);
        else begin
          logic [7:0] e;
          string t;
          e = expData.pop_front(); t = expDataTag.pop_front();
          check(dataByte == e, t, "data byte", dataByte, e);
        end
      end
      if (done) check(prevCeN && nandCeN, "R10", "chip enable high before done", prevCeN, 1);
      prevWe = nandWeN; prevRe = nandReN; prevLatch = latchOn; prevCeN = nandCeN;
    end
  end

  task automatic runOp(logic [1:0] op, logic [AW-1:0] off);
    logic [7:0] colHi;
    case (op)
      2'd0: begin expectWr(1, 0, 8'hFF, "R8"); expectWr(1, 0, 8'h70, "R8"); end
      2'd1: begin
        expectWr(1, 0, 8'h90, "R9"); expectWr(0, 1, 8'h00, "R9");
        expectData(idMfr, "R9"); expectData(idDev, "R9");
      end
      default: begin
        colHi = {4'b0, (op == 2'd3), off[10:8]};
        expectWr(1, 0, 8'h00, "R4");
        expectWr(0, 1, off[7:0], "R4");
        expectWr(0, 1, colHi, (op == 2'd3) ? "R7" : "R4");
        expectWr(0, 1, off[18:11], "R4");
        expectWr(0, 1, off[26:19], "R4");
        expectWr(0, 1, off[34:27], "R4");
        expectWr(1, 0, 8'h30, "R4");
        if (op == 2'd2) for (int k = 0; k < PG + SP; k++) expectData(pageByte(k), "R6");
        else            for (int k = 0; k < SP; k++)      expectData(spareByte(k), "R7");
      end
    endcase
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1; reqOp = op; reqOffset = off;
    @(negedge clk);
    reqValid = 0;
    while (!done) @(negedge clk);
    check(expWr.size() == 0, "R1", "writes left over", expWr.size(), 0);
    check(expData.size() == 0, "R6", "data left over", expData.size(), 0);
    @(negedge clk);
    check(reqReady == 1, "R1", "ready after done", reqReady, 1);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady == 1, "R1", "reset ready", reqReady, 1);
    check(nandCeN && nandWeN && nandReN, "R10", "reset strobes idle",
          {nandCeN, nandWeN, nandReN}, 3'b111);
    check(!nandCle && !nandAle && !dataValid && !idMatch, "R9", "reset flags low",
          {nandCle, nandAle, dataValid, idMatch}, 0);
    rstN = 1;
    @(negedge clk);

    // R8: reset with three busy status polls
    pollTarget = 3;
    runOp(2'd0, '0);
    check(pollCnt == 4, "R8", "status reads", pollCnt, 4);

    // R9: identify, several pairs
    idMfr = 8'h2C; idDev = 8'hA1; runOp(2'd1, '0);
    check(idMatch == 1, "R9", "id 2C/A1", idMatch, 1);
    idMfr = 8'h2C; idDev = 8'hBB; runOp(2'd1, '0);
    check(idMatch == 0, "R9", "id 2C/BB", idMatch, 0);
    idMfr = 8'hEC; idDev = 8'hA1; runOp(2'd1, '0);
    check(idMatch == 1, "R9", "id EC/A1", idMatch, 1);
    idMfr = 8'hEC; idDev = 8'hBA; runOp(2'd1, '0);
    check(idMatch == 0, "R9", "id EC/BA", idMatch, 0);
    idMfr = 8'h2C; idDev = 8'hBC; runOp(2'd1, '0);
    check(idMatch == 1, "R9", "id 2C/BC", idMatch, 1);

    // R4 R6 R1: page read with a stray request mid-stream
    fork
      runOp(2'd2, {8'h5B, 8'hC6, 8'h1E, 11'h3A5});
      begin
        repeat (400) @(negedge clk);
        check(reqReady == 0, "R1", "ready while busy", reqReady, 0);
        reqValid = 1; reqOp = 2'd1;
        repeat (3) @(negedge clk);
        reqValid = 0;
      end
    join
    check(idMatch == 1, "R9", "id held across page read", idMatch, 1);

    // R7: spare read
    runOp(2'd3, {8'h01, 8'h80, 8'h7F, 11'h010});

    // R8: reset that is ready at once
    pollTarget = 0;
    runOp(2'd0, '0);
    check(pollCnt == 1, "R8", "single status read", pollCnt, 1);

    summary();
    $finish;
  end

endmodule